// File: doc/BRIEF.md
# Dual Threshold Alarm Monitor

This block watches a set of sensor data lanes and raises up to two independent alarm flags. Each of the two channels picks one lane by a 4-bit source code, takes either the conditioned (filtered) or the raw copy of that lane, and compares a 14-bit signed figure against a signed limit. The figure is either the present sample itself (level mode) or the present sample minus the sample taken a programmable number of strobes earlier (slope mode). The limit word also carries a direction bit, so a channel trips either above or below its limit.

Comparisons happen only on the cycle where the sample strobe is high. A tripped channel keeps its flag until the status is read. A read clears both flags; a channel whose condition still holds trips again on the next strobe. The OR of the two flags can be shown on one of two output lines, at a chosen polarity. Data generation and register access sit outside the block: every control field arrives as a parallel input.

Top module: `dual_alarm_monitor`

## Requirements
- R1: Source codes select lanes as follows, where lane n occupies bits [14n+13:14n] of each data bus: 1 supply (lane 0), 2 gyro (lane 1), 5/6/7 acceleration X/Y/Z (lanes 2/3/4), 8 temperature (lane 5), 9 pitch (lane 6), 10 roll (lane 7), 11 auxiliary input (lane 8). Code 0 and codes 3, 4 and 12 to 15 select nothing, and such a channel never trips.
- R2: Bit 15 of a channel's limit word sets the direction (1: trip when the figure is strictly greater than the limit, 0: strictly less). Bits 13:0 hold the limit as 14-bit two's complement. Bit 14 has no effect.
- R3: With the channel's slope bit at 0, the figure is the present sample of the selected lane, read as a 14-bit signed value.
- R4: With the slope bit at 1, the figure is the present sample minus the sample K strobes earlier. K is the 8-bit span field, and spans 0 and 1 both mean the previous strobe. The channel cannot trip in slope mode until at least K strobes have happened since reset.
- R5: With use_filtered at 1 a channel reads the filtered bus, and with it at 0 the raw bus. Pitch (code 9) and roll (code 10) always read the filtered bus.
- R6: Flags are 0 after reset. Flags change only on a strobe or a status read. A strobe whose condition holds sets the flag on the following clock edge. A strobe whose condition fails leaves a set flag set.
- R7: A status read without a strobe clears both flags on the next edge. When a read and a strobe fall in the same cycle, each flag takes that strobe's condition.
- R8: The inactive level of both lines is the inverse of pin_active_high. While pin_en is 1, the selected line (line2 when pin_sel_line2 is 1, line1 when 0) carries the OR of the two flags at the programmed polarity. The other line, and both lines while pin_en is 0, sit at the inactive level.
- R9: The two channels are independent. Each channel records its selected sample, 0 for a code that selects nothing, on every strobe in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | New-sample strobe, one cycle per sample |
| rd_status | input | 1 | Status read pulse, clears flags |
| raw_data | input | 126 | Nine 14-bit unfiltered lanes |
| filt_data | input | 126 | Nine 14-bit filtered lanes |
| use_filtered | input | 1 | Compare filtered lanes |
| ch0_src | input | 4 | Channel 0 source code |
| ch0_limit | input | 16 | Channel 0 direction and limit |
| ch0_rate | input | 1 | Channel 0 slope mode |
| ch0_span | input | 8 | Channel 0 slope span in strobes |
| ch1_src | input | 4 | Channel 1 source code |
| ch1_limit | input | 16 | Channel 1 direction and limit |
| ch1_rate | input | 1 | Channel 1 slope mode |
| ch1_span | input | 8 | Channel 1 slope span in strobes |
| pin_en | input | 1 | Enable the alarm line |
| pin_active_high | input | 1 | Alarm line polarity, 1 active high |
| pin_sel_line2 | input | 1 | Drive line2 (1) or line1 (0) |
| alarm_flags | output | 2 | Sticky per-channel flags |
| line1 | output | 1 | First alarm output line |
| line2 | output | 1 | Second alarm output line |

## Verification
The source codes are stepped through with the chosen lane set above the limit and every other lane below it. This separates a correct lane map from one that swaps or aliases lanes, and it shows that the unused codes stay silent. Values equal to the limit, on both sides of it and with negative limits, separate strict from non-strict comparison and signed from unsigned reading. Ramps and steps in slope mode at spans 0, 1, 3 and 255, one run of them right after a reset, separate the right history depth from one strobe off and show the fill gating. A long stretch of random data, controls, strobes and reads is compared each cycle against a queue-based model and catches faults in stickiness, read priority and line steering.

// File: rtl/alm_pkg.sv
`timescale 1ns/1ps
package alm_pkg;
   localparam int NUM_LANES = 9;
   localparam int CODE_W    = 4;
   localparam int LANE_W    = 4;

   typedef struct packed {
      logic              valid;
      logic [LANE_W-1:0] lane;
      logic              force_filt;
   } lane_sel_t;

   // Source code to lane decode; angle lanes are tied to filtered data.
   function automatic lane_sel_t decode_src(input logic [CODE_W-1:0] code);
      lane_sel_t r;
      r.valid      = 1'b1;
      r.lane       = '0;
      r.force_filt = 1'b0;
      case (code)
         4'd1:    r.lane = 4'd0;
         4'd2:    r.lane = 4'd1;
         4'd5:    r.lane = 4'd2;
         4'd6:    r.lane = 4'd3;
         4'd7:    r.lane = 4'd4;
         4'd8:    r.lane = 4'd5;
         4'd9:    begin r.lane = 4'd6; r.force_filt = 1'b1; end
         4'd10:   begin r.lane = 4'd7; r.force_filt = 1'b1; end
         4'd11:   r.lane = 4'd8;
         default: r.valid = 1'b0;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/alm_src_mux.sv
`timescale 1ns/1ps
module alm_src_mux
   import alm_pkg::*;
#(
   parameter int DW = 14
) (
   input  logic [NUM_LANES*DW-1:0] raw_bus,
   input  logic [NUM_LANES*DW-1:0] filt_bus,
   input  logic [CODE_W-1:0]       code,
   input  logic                    use_filt,
   output logic [DW-1:0]           sample,
   output logic                    sample_ok
);
   lane_sel_t        sel;
   logic [DW-1:0]    raw_l  [NUM_LANES];
   logic [DW-1:0]    filt_l [NUM_LANES];

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      assign raw_l[i]  = raw_bus[i*DW +: DW];
      assign filt_l[i] = filt_bus[i*DW +: DW];
   end

   assign sel       = decode_src(code);
   assign sample_ok = sel.valid;

   always_comb begin
      sample = '0;
      if (sel.valid) begin
         sample = (use_filt || sel.force_filt) ? filt_l[sel.lane] : raw_l[sel.lane];
      end
   end
endmodule

// File: rtl/alm_history.sv
`timescale 1ns/1ps
module alm_history #(
   parameter int DW    = 14,
   parameter int KW    = 8,
   parameter int DEPTH = 255
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic [KW-1:0] span,
   output logic [DW-1:0] past,
   output logic          past_ok
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = PW + 1;

   if (DEPTH < (1 << KW) - 1) begin : g_bad_depth
      $error("alm_history: DEPTH must cover the largest span");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wptr;
   logic [CW-1:0] fill;
   logic [CW-1:0] keff;
   logic [CW-1:0] rd_full;
   logic [PW-1:0] rd_idx;

   always_comb begin
      keff = (span <= KW'(1)) ? CW'(1) : CW'(span);
      if ({1'b0, wptr} >= keff) rd_full = {1'b0, wptr} - keff;
      else                      rd_full = {1'b0, wptr} + CW'(DEPTH) - keff;
      rd_idx = rd_full[PW-1:0];
   end

   assign past    = mem[rd_idx];
   assign past_ok = (fill >= keff);

   always_ff @(posedge clk) begin
      if (push) mem[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         fill <= '0;
      end else if (push) begin
         wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + PW'(1);
         if (fill != CW'(DEPTH)) fill <= fill + CW'(1);
      end
   end
endmodule

// File: rtl/alm_compare.sv
`timescale 1ns/1ps
module alm_compare #(
   parameter int DW = 14,
   parameter int LW = 16
) (
   input  logic [DW-1:0] sample,
   input  logic          sample_ok,
   input  logic [DW-1:0] past,
   input  logic          past_ok,
   input  logic          rate_mode,
   input  logic [LW-1:0] limit,
   output logic          hit
);
   localparam int XW = DW + 1;

   if (LW < DW + 2) begin : g_bad_lw
      $error("alm_compare: limit word too narrow for sense bit");
   end

   logic signed [XW-1:0] cur_x, past_x, diff_x, thr_x, metric;
   logic                 armed;
   logic                 lim_unused;

   assign lim_unused = ^limit[LW-2:DW];

   always_comb begin
      cur_x  = signed'({sample[DW-1], sample});
      past_x = signed'({past[DW-1], past});
      diff_x = cur_x - past_x;
      thr_x  = signed'({limit[DW-1], limit[DW-1:0]});
      metric = rate_mode ? diff_x : cur_x;
      armed  = sample_ok && (!rate_mode || past_ok);
      hit    = armed && (limit[LW-1] ? (metric > thr_x) : (metric < thr_x));
   end
endmodule

// File: rtl/dual_alarm_monitor.sv
`timescale 1ns/1ps
module dual_alarm_monitor
   import alm_pkg::*;
#(
   parameter int DW    = 14,
   parameter int LW    = 16,
   parameter int KW    = 8,
   parameter int DEPTH = 255
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    smp_stb,
   input  logic                    rd_status,
   input  logic [NUM_LANES*DW-1:0] raw_data,
   input  logic [NUM_LANES*DW-1:0] filt_data,
   input  logic                    use_filtered,
   input  logic [CODE_W-1:0]       ch0_src,
   input  logic [LW-1:0]           ch0_limit,
   input  logic                    ch0_rate,
   input  logic [KW-1:0]           ch0_span,
   input  logic [CODE_W-1:0]       ch1_src,
   input  logic [LW-1:0]           ch1_limit,
   input  logic                    ch1_rate,
   input  logic [KW-1:0]           ch1_span,
   input  logic                    pin_en,
   input  logic                    pin_active_high,
   input  logic                    pin_sel_line2,
   output logic [1:0]              alarm_flags,
   output logic                    line1,
   output logic                    line2
);
   localparam int NCH = 2;

   if (DW < 2) begin : g_bad_dw
      $error("dual_alarm_monitor: DW too small");
   end

   logic [CODE_W-1:0] src_a  [NCH];
   logic [LW-1:0]     lim_a  [NCH];
   logic              rate_a [NCH];
   logic [KW-1:0]     span_a [NCH];
   logic [NCH-1:0]    flag_w;

   assign src_a[0]  = ch0_src;
   assign src_a[1]  = ch1_src;
   assign lim_a[0]  = ch0_limit;
   assign lim_a[1]  = ch1_limit;
   assign rate_a[0] = ch0_rate;
   assign rate_a[1] = ch1_rate;
   assign span_a[0] = ch0_span;
   assign span_a[1] = ch1_span;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [DW-1:0] smp, past;
      logic          smp_ok, past_ok, hit, flag_q;

      alm_src_mux #(.DW(DW)) u_mux (
         .raw_bus   (raw_data),
         .filt_bus  (filt_data),
         .code      (src_a[c]),
         .use_filt  (use_filtered),
         .sample    (smp),
         .sample_ok (smp_ok)
      );

      alm_history #(.DW(DW), .KW(KW), .DEPTH(DEPTH)) u_hist (
         .clk     (clk),
         .rst_n   (rst_n),
         .push    (smp_stb),
         .din     (smp),
         .span    (span_a[c]),
         .past    (past),
         .past_ok (past_ok)
      );

      alm_compare #(.DW(DW), .LW(LW)) u_cmp (
         .sample    (smp),
         .sample_ok (smp_ok),
         .past      (past),
         .past_ok   (past_ok),
         .rate_mode (rate_a[c]),
         .limit     (lim_a[c]),
         .hit       (hit)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         flag_q <= 1'b0;
         else if (smp_stb)   flag_q <= hit | (flag_q & ~rd_status);
         else if (rd_status) flag_q <= 1'b0;
      end

      assign flag_w[c] = flag_q;
   end

   logic any_alm, idle_lvl, act_lvl;

   assign any_alm     = |flag_w;
   assign idle_lvl    = ~pin_active_high;
   assign act_lvl     = (pin_en && any_alm) ? pin_active_high : idle_lvl;
   assign line1       = pin_sel_line2 ? idle_lvl : act_lvl;
   assign line2       = pin_sel_line2 ? act_lvl : idle_lvl;
   assign alarm_flags = flag_w;
endmodule

// File: rtl/alm_monitor_chk.sv
`timescale 1ns/1ps
module alm_monitor_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       smp_stb,
   input logic       rd_status,
   input logic [3:0] ch0_src,
   input logic [3:0] ch1_src,
   input logic       pin_en,
   input logic       pin_active_high,
   input logic       pin_sel_line2,
   input logic [1:0] alarm_flags,
   input logic       line1,
   input logic       line2
);
   p_rd_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_status && !smp_stb) |=> (alarm_flags == 2'b00));

   p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_stb && !rd_status) |=> $stable(alarm_flags));

   p_rise0_on_stb_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_flags[0]) |-> $past(smp_stb));

   p_rise1_on_stb_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_flags[1]) |-> $past(smp_stb));

   p_off0_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && rd_status && ch0_src == 4'd0) |=> !alarm_flags[0]);

   p_off1_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && rd_status && ch1_src == 4'd0) |=> !alarm_flags[1]);

   p_lines_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_en |-> (line1 == !pin_active_high && line2 == !pin_active_high));

   p_unsel_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pin_sel_line2 ? (line1 == !pin_active_high) : (line2 == !pin_active_high));
endmodule

bind dual_alarm_monitor alm_monitor_chk u_chk (.*);

// File: tb/dual_alarm_monitor_bench.sv
`timescale 1ns/1ps
module dual_alarm_monitor_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_stb = 1'b0;
   logic rd_status = 1'b0;
   logic use_filtered = 1'b0;
   logic pin_en = 1'b0, pin_active_high = 1'b1, pin_sel_line2 = 1'b0;
   logic [3:0]  src [2];
   logic [15:0] lim [2];
   logic        rt  [2];
   logic [7:0]  spn [2];
   int          raw_v  [9];
   int          filt_v [9];
   logic [125:0] raw_bus, filt_bus;
   logic [1:0]  alarm_flags;
   logic        line1, line2;

   int checks = 0, failures = 0;
   string req_tag = "R6";
   int hq0[$], hq1[$];
   logic [1:0] exp_f = 2'b00;

   always #2.5 clk = ~clk;

   always_comb begin
      for (int i = 0; i < 9; i++) begin
         raw_bus[i*14 +: 14]  = raw_v[i][13:0];
         filt_bus[i*14 +: 14] = filt_v[i][13:0];
      end
   end

   dual_alarm_monitor u_dual_alarm_monitor (
      .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .rd_status(rd_status),
      .raw_data(raw_bus), .filt_data(filt_bus), .use_filtered(use_filtered),
      .ch0_src(src[0]), .ch0_limit(lim[0]), .ch0_rate(rt[0]), .ch0_span(spn[0]),
      .ch1_src(src[1]), .ch1_limit(lim[1]), .ch1_rate(rt[1]), .ch1_span(spn[1]),
      .pin_en(pin_en), .pin_active_high(pin_active_high), .pin_sel_line2(pin_sel_line2),
      .alarm_flags(alarm_flags), .line1(line1), .line2(line2)
   );

   task automatic check(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic int lane_of(input int code);
      case (code)
         1: return 0;  2: return 1;  5: return 2;  6: return 3;  7: return 4;
         8: return 5;  9: return 6;  10: return 7; 11: return 8;
         default: return -1;
      endcase
   endfunction

   function automatic int sx(input int v);
      int t;
      t = v & 32'h3fff;
      return (t >= 8192) ? t - 16384 : t;
   endfunction

   function automatic int pick(input int c);
      int code, l;
      code = int'(src[c]);
      l = lane_of(code);
      if (l < 0) return 0;
      return sx((use_filtered || code == 9 || code == 10) ? filt_v[l] : raw_v[l]);
   endfunction

   function automatic bit model_hit(input int c);
      int cur, thr, m, n, k, past;
      if (lane_of(int'(src[c])) < 0) return 1'b0;
      cur = pick(c);
      thr = sx(int'(lim[c][13:0]));
      if (rt[c]) begin
         n = (c == 0) ? hq0.size() : hq1.size();
         k = (spn[c] <= 1) ? 1 : int'(spn[c]);
         if (n < k) return 1'b0;
         past = (c == 0) ? hq0[n-k] : hq1[n-k];
         m = cur - past;
      end else begin
         m = cur;
      end
      return lim[c][15] ? (m > thr) : (m < thr);
   endfunction

   function automatic logic [1:0] exp_lines();
      logic idle, act;
      idle = !pin_active_high;
      act  = (pin_en && (|exp_f)) ? pin_active_high : idle;
      return pin_sel_line2 ? {act, idle} : {idle, act};
   endfunction

   task automatic step(input bit stb, input bit rd);
      bit h0, h1;
      int v0, v1;
      @(negedge clk);
      smp_stb = stb;
      rd_status = rd;
      if (stb) begin
         h0 = model_hit(0);
         h1 = model_hit(1);
         v0 = pick(0);
         v1 = pick(1);
         exp_f[0] = h0 | (exp_f[0] & !rd);
         exp_f[1] = h1 | (exp_f[1] & !rd);
         hq0.push_back(v0); if (hq0.size() > 255) void'(hq0.pop_front());
         hq1.push_back(v1); if (hq1.size() > 255) void'(hq1.pop_front());
      end else if (rd) begin
         exp_f = 2'b00;
      end
      @(posedge clk);
      #1;
      check(req_tag, int'(alarm_flags), int'(exp_f), "flags vs model");
      check(req_tag, int'({line2, line1}), int'(exp_lines()), "lines vs model");
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      smp_stb = 1'b0;
      rd_status = 1'b0;
      hq0.delete();
      hq1.delete();
      exp_f = 2'b00;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic set_all(input int v);
      for (int i = 0; i < 9; i++) begin raw_v[i] = v; filt_v[i] = v; end
   endtask

   initial begin
      #(150000 * 5);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int c = 0; c < 2; c++) begin src[c] = 4'd0; lim[c] = 16'h0; rt[c] = 1'b0; spn[c] = 8'd0; end
      set_all(0);
      repeat (3) @(negedge clk);
      // R6 reset state, R8 idle levels both polarities
      check("R6", int'(alarm_flags), 0, "flags in reset");
      check("R8", int'({line2, line1}), 0, "idle lines active-high");
      pin_active_high = 1'b0;
      #1;
      check("R8", int'({line2, line1}), 3, "idle lines active-low");
      pin_active_high = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;

      // R3 static level, gyro, greater than 100
      req_tag = "R3";
      src[0] = 4'd2; lim[0] = 16'h8000 | 16'd100;
      raw_v[1] = 50;  step(1, 1);
      check("R3", int'(alarm_flags[0]), 0, "gyro 50 > 100");
      raw_v[1] = 150; step(1, 1);
      check("R3", int'(alarm_flags[0]), 1, "gyro 150 > 100");
      raw_v[1] = 100; step(1, 1);
      check("R2", int'(alarm_flags[0]), 0, "equal is not greater");
      // R6 sticky
      req_tag = "R6";
      raw_v[1] = 150; step(1, 0);
      raw_v[1] = 20;  step(1, 0);
      check("R6", int'(alarm_flags[0]), 1, "flag sticks after false sample");
      step(0, 0); step(0, 0);
      check("R6", int'(alarm_flags[0]), 1, "flag holds without strobe");
      // R7 clear and re-arm
      req_tag = "R7";
      raw_v[1] = 150;
      step(0, 1);
      check("R7", int'(alarm_flags[0]), 0, "read clears");
      step(0, 0);
      check("R7", int'(alarm_flags[0]), 0, "no re-arm without strobe");
      step(1, 0);
      check("R7", int'(alarm_flags[0]), 1, "re-arms on next strobe");
      raw_v[1] = 10; step(1, 1);
      check("R7", int'(alarm_flags[0]), 0, "coincident read and false strobe");

      // R2 less-than with negative limit on channel 1, bit 14 ignored
      req_tag = "R2";
      src[0] = 4'd0;
      src[1] = 4'd5; lim[1] = 16'h4000 | (16'hffec & 16'h3fff);
      raw_v[2] = -30; step(1, 1);
      check("R2", int'(alarm_flags[1]), 1, "-30 < -20");
      raw_v[2] = -20; step(1, 1);
      check("R2", int'(alarm_flags[1]), 0, "-20 not < -20");
      raw_v[2] = 5;   step(1, 1);
      check("R2", int'(alarm_flags[1]), 0, "5 not < -20 (signed)");
      lim[1] = 16'h8000 | 16'h1fff;
      raw_v[2] = 8191; step(1, 1);
      check("R2", int'(alarm_flags[1]), 0, "nothing exceeds max limit");
      src[1] = 4'd0;

      // R1 lane map over all codes
      req_tag = "R1";
      lim[0] = 16'h8000;
      for (int code = 0; code < 16; code++) begin
         src[0] = 4'(code);
         for (int i = 0; i < 9; i++) begin
            raw_v[i]  = (i == lane_of(code)) ? 500 : -500;
            filt_v[i] = raw_v[i];
         end
         step(1, 1);
         check("R1", int'(alarm_flags[0]), (lane_of(code) >= 0) ? 1 : 0, $sformatf("code %0d", code));
      end

      // R5 filtered vs raw, angle lanes forced filtered
      req_tag = "R5";
      lim[0] = 16'h8000 | 16'd100;
      set_all(0);
      src[0] = 4'd2; raw_v[1] = 0; filt_v[1] = 300;
      use_filtered = 1'b0; step(1, 1);
      check("R5", int'(alarm_flags[0]), 0, "raw gyro chosen");
      use_filtered = 1'b1; step(1, 1);
      check("R5", int'(alarm_flags[0]), 1, "filtered gyro chosen");
      use_filtered = 1'b0;
      src[0] = 4'd9; raw_v[6] = 0; filt_v[6] = 300; step(1, 1);
      check("R5", int'(alarm_flags[0]), 1, "pitch always filtered");
      src[0] = 4'd10; raw_v[7] = 300; filt_v[7] = 0; step(1, 1);
      check("R5", int'(alarm_flags[0]), 0, "roll ignores raw");

      // R4 slope mode right after reset, span 3, fill gating
      req_tag = "R4";
      do_reset();
      set_all(0);
      src[0] = 4'd2; rt[0] = 1'b1; spn[0] = 8'd3; lim[0] = 16'h8000 | 16'd50;
      raw_v[1] = 0;   step(1, 1);
      raw_v[1] = 100; step(1, 1);
      check("R4", int'(alarm_flags[0]), 0, "one earlier sample is not enough");
      step(1, 1);
      check("R4", int'(alarm_flags[0]), 0, "two earlier samples are not enough");
      step(1, 1);
      check("R4", int'(alarm_flags[0]), 1, "100 minus 0 three back");
      step(1, 1);
      check("R4", int'(alarm_flags[0]), 0, "100 minus 100 three back");
      // span 0 behaves as span 1
      spn[0] = 8'd0;
      raw_v[1] = 170; step(1, 1);
      check("R4", int'(alarm_flags[0]), 1, "span 0 uses previous");
      step(1, 1);
      check("R4", int'(alarm_flags[0]), 0, "span 0 flat");
      spn[0] = 8'd1; raw_v[1] = 100; lim[0] = 16'h0000 | (16'hffce & 16'h3fff);
      step(1, 1);
      check("R4", int'(alarm_flags[0]), 1, "falling slope below -50");
      // span 255 over a ramp
      spn[0] = 8'd255; lim[0] = 16'h8000 | 16'd1000;
      for (int i = 0; i < 300; i++) begin
         raw_v[1] = (i * 5) % 1600 - 800;
         step(1, 1);
      end

      // R8 all line configurations with flag set and clear
      req_tag = "R8";
      rt[0] = 1'b0; src[0] = 4'd2; lim[0] = 16'h8000; raw_v[1] = 10;
      for (int cfg = 0; cfg < 8; cfg++) begin
         pin_en = cfg[0]; pin_active_high = cfg[1]; pin_sel_line2 = cfg[2];
         step(1, 1);
         step(0, 1);
      end
      pin_en = 1'b1; pin_active_high = 1'b0; pin_sel_line2 = 1'b1;
      step(1, 1);
      check("R8", int'({line2, line1}), 1, "line2 low active, line1 idle high");

      // R9 independence and random traffic against the model
      req_tag = "R9";
      src[1] = 4'd0; src[0] = 4'd2; step(1, 1);
      check("R9", int'(alarm_flags), 1, "only channel 0 trips");
      for (int it = 0; it < 3000; it++) begin
         if ($urandom_range(0, 7) == 0) begin
            for (int c = 0; c < 2; c++) begin
               src[c] = 4'($urandom_range(0, 15));
               lim[c] = 16'($urandom);
               rt[c]  = 1'($urandom_range(0, 1));
               spn[c] = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 4));
            end
            use_filtered = 1'($urandom_range(0, 1));
            pin_en = 1'($urandom_range(0, 1));
            pin_active_high = 1'($urandom_range(0, 1));
            pin_sel_line2 = 1'($urandom_range(0, 1));
         end
         for (int i = 0; i < 9; i++) begin
            raw_v[i]  = $urandom_range(0, 16383);
            filt_v[i] = $urandom_range(0, 16383);
         end
         step($urandom_range(0, 2) != 0, $urandom_range(0, 3) == 0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule